// File: doc/BRIEF.md
# LRU Set-Associative Tag Store

This block answers one question per request: would a cache of the configured geometry have held the addressed bytes? It keeps only the tag and recency state of one cache level. It has no data array, no dirty bits and no write-back path. Every miss installs its line at once, as a write-allocate cache would. The capacity, the number of ways and the line length are parameters, and each must be a power of two.

A request carries a byte address and a byte count. The block splits the address into a block number (the address shifted right by log2 of the line length) and a set index (the low bits of that block number). It then searches the ways of that set. The ways of a set are kept in recency order, with way 0 the most recently used. A request whose last byte lies in the next line performs two lookups, one per line, on consecutive cycles. It still returns a single answer. A request spanning more than two lines is rejected with an error flag.

Requests and responses both use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while the second lookup of a straddling request is in progress. It is also low while a response is waiting and `rsp_ready` is low. A response stays valid, with unchanged flags, until it is taken on an edge where `rsp_valid` and `rsp_ready` are both high.

Top module: `lru_tag_store`

## Requirements
- R1: The block number is `req_addr >> log2(LINE_BYTES)`. The set index is the block number masked with `SETS-1`, where `SETS = CACHE_BYTES / LINE_BYTES / WAYS`. Bytes within one line share one entry.
- R2: Reset clears every stored tag to zero, and there is no valid bit. After reset, an access to block number 0 therefore hits, and any other block misses on its first access.
- R3: On a miss, the new block number goes into way 0 and every way shifts down by one. The tag that was in the last way is discarded.
- R4: A hit in a way other than way 0 moves that tag to way 0. The ways above it shift down by one, and the ways below it keep their places.
- R5: A hit in way 0 leaves the order of the set unchanged.
- R6: The stored tag is the whole block number. Blocks with the same set index but different upper bits never alias.
- R7: A request whose first and last byte share a line does one lookup. Its response is valid in the cycle after acceptance, and `req_ready` stays high when `rsp_ready` is high.
- R8: A request whose last byte lies in the next line looks up and updates both sets, on two cycles. `req_ready` is low in the second cycle. One response follows two cycles after acceptance, with `rsp_miss` set if either line missed.
- R9: A request spanning more than two lines returns `rsp_err=1` and `rsp_miss=0` one cycle after acceptance, and changes no tag state.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response flags hold steady and `req_ready` is low.
- R11: With `WAYS=1`, the block acts as a direct-mapped cache. Each miss replaces the single entry of its set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_size | input | SIZE_W | Number of bytes accessed (1 or more) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_miss | output | 1 | Request missed (either line for a straddle) |
| rsp_err | output | 1 | Request spanned more than two lines |

## Verification
A wrong tag value or a wrong recency order does not show at once. It shows later, as a hit where a miss was due or the reverse, and only when an eviction or a re-reference touches the damaged way. The directed tests therefore fill a set past its associativity and then probe the tag that should have survived and the tag that should have left. This catches an order fault within one to five accesses. A wrong shift is exposed by the probe following the first promotion. A wrong straddle sequence shows as a response that arrives at the wrong cycle, or as a second line that was never installed.

// File: rtl/lru_pkg.sv
package lru_pkg;
  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SECOND = 1'b1
  } lru_state_e;
endpackage

// File: rtl/lru_addr_split.sv
module lru_addr_split #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 5,
  parameter int OFF_W  = 4,
  localparam int BLK_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  output logic [BLK_W-1:0]  blk_first,
  output logic [BLK_W-1:0]  blk_last,
  output logic              one_line,
  output logic              two_line
);
  logic [ADDR_W-1:0] last_byte;

  // last byte touched; wraps at the top of the address space
  assign last_byte = addr + ADDR_W'(size) - ADDR_W'(1);
  assign blk_first = addr[ADDR_W-1:OFF_W];
  assign blk_last  = last_byte[ADDR_W-1:OFF_W];
  assign one_line  = (blk_last == blk_first);
  assign two_line  = (blk_last == blk_first + BLK_W'(1));
endmodule

// File: rtl/lru_set_update.sv
module lru_set_update #(
  parameter int WAYS  = 4,
  parameter int BLK_W = 28
) (
  input  logic [WAYS-1:0][BLK_W-1:0] row,
  input  logic [BLK_W-1:0]           tag,
  output logic                       hit,
  output logic [WAYS-1:0][BLK_W-1:0] nxt
);
  int pos;

  // lowest matching way wins; on a miss the shift reaches the last way
  always_comb begin
    hit = 1'b0;
    pos = WAYS - 1;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (row[w] == tag) begin
        hit = 1'b1;
        pos = w;
      end
    end
  end

  assign nxt[0] = tag;

  for (genvar g = 1; g < WAYS; g++) begin : g_shift
    assign nxt[g] = (g <= pos) ? row[g-1] : row[g];
  end
endmodule

// File: rtl/lru_tag_store.sv
module lru_tag_store
  import lru_pkg::*;
#(
  parameter int CACHE_BYTES = 1024,
  parameter int WAYS        = 4,
  parameter int LINE_BYTES  = 16,
  parameter int ADDR_W      = 32,
  parameter int SIZE_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_miss,
  output logic              rsp_err
);
  localparam int SETS  = CACHE_BYTES / LINE_BYTES / WAYS;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int BLK_W = ADDR_W - OFF_W;

  logic [WAYS-1:0][BLK_W-1:0] tags [SETS];

  lru_state_e        state;
  logic [BLK_W-1:0]  pend_blk;
  logic              pend_miss;

  logic [BLK_W-1:0]  blk_first, blk_last, lk_blk;
  logic              one_line, two_line, accept, span_bad, do_write, hit;
  logic [IDX_W-1:0]  lk_set;
  logic [WAYS-1:0][BLK_W-1:0] row, nxt;

  lru_addr_split #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .OFF_W(OFF_W)) u_split (
    .addr(req_addr), .size(req_size),
    .blk_first(blk_first), .blk_last(blk_last),
    .one_line(one_line), .two_line(two_line)
  );

  assign req_ready = (state == ST_IDLE) && (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;
  assign span_bad  = !one_line && !two_line;

  assign lk_blk = (state == ST_SECOND) ? pend_blk : blk_first;
  assign lk_set = IDX_W'(lk_blk & BLK_W'(SETS - 1));
  assign row    = tags[lk_set];

  lru_set_update #(.WAYS(WAYS), .BLK_W(BLK_W)) u_upd (
    .row(row), .tag(lk_blk), .hit(hit), .nxt(nxt)
  );

  assign do_write = (accept && !span_bad) || (state == ST_SECOND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tags[s] <= '0;
      state     <= ST_IDLE;
      pend_blk  <= '0;
      pend_miss <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      if (do_write) tags[lk_set] <= nxt;
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (one_line) begin
              rsp_valid <= 1'b1;
              rsp_miss  <= !hit;
              rsp_err   <= 1'b0;
            end else if (two_line) begin
              pend_blk  <= blk_last;
              pend_miss <= !hit;
              state     <= ST_SECOND;
            end else begin
              rsp_valid <= 1'b1;
              rsp_miss  <= 1'b0;
              rsp_err   <= 1'b1;
            end
          end
        end
        ST_SECOND: begin
          rsp_valid <= 1'b1;
          rsp_miss  <= pend_miss || !hit;
          rsp_err   <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r8_busy_second: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SECOND) |-> !req_ready);

  a_r8_second_responds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SECOND) |=> (rsp_valid && !rsp_err));

  a_r7_single_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && one_line) |=> (rsp_valid && !rsp_err && state == ST_IDLE));

  a_r9_err_response: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && span_bad) |=> (rsp_valid && rsp_err && !rsp_miss));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_miss) && $stable(rsp_err)));

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

// File: tb/lru_tag_store_test.sv
`timescale 1ns/1ps
module lru_tag_store_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  logic        m_req_valid = 0, m_rsp_ready = 1;
  logic [31:0] m_req_addr = 0;
  logic [4:0]  m_req_size = 1;
  logic        m_req_ready, m_rsp_valid, m_rsp_miss, m_rsp_err;

  logic        d_req_valid = 0, d_rsp_ready = 1;
  logic [31:0] d_req_addr = 0;
  logic [4:0]  d_req_size = 1;
  logic        d_req_ready, d_rsp_valid, d_rsp_miss, d_rsp_err;

  lru_tag_store uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(m_req_valid), .req_ready(m_req_ready),
    .req_addr(m_req_addr), .req_size(m_req_size),
    .rsp_valid(m_rsp_valid), .rsp_ready(m_rsp_ready),
    .rsp_miss(m_rsp_miss), .rsp_err(m_rsp_err)
  );

  lru_tag_store #(.CACHE_BYTES(256), .WAYS(1), .LINE_BYTES(16)) uut_dm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(d_req_valid), .req_ready(d_req_ready),
    .req_addr(d_req_addr), .req_size(d_req_size),
    .rsp_valid(d_rsp_valid), .rsp_ready(d_rsp_ready),
    .rsp_miss(d_rsp_miss), .rsp_err(d_rsp_err)
  );

  logic sel = 1'b0;
  logic c_ready, c_rv, c_miss, c_err;
  assign c_ready = sel ? d_req_ready : m_req_ready;
  assign c_rv    = sel ? d_rsp_valid : m_rsp_valid;
  assign c_miss  = sel ? d_rsp_miss  : m_rsp_miss;
  assign c_err   = sel ? d_rsp_err   : m_rsp_err;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    m_req_valid = 0; d_req_valid = 0; m_rsp_ready = 1; d_rsp_ready = 1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one request; checks miss, err, latency and ready after acceptance
  task automatic access(input bit dm, input logic [31:0] a, input logic [4:0] sz,
                        input bit exp_miss, input bit exp_err, input int exp_lat,
                        input string req);
    int lat;
    bit rdy1;
    @(negedge clk);
    sel = dm;
    if (dm) begin d_req_valid = 1; d_req_addr = a; d_req_size = sz; end
    else    begin m_req_valid = 1; m_req_addr = a; m_req_size = sz; end
    #1;
    while (!c_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    m_req_valid = 0; d_req_valid = 0;
    lat = 1;
    rdy1 = c_ready;
    while (!c_rv && lat < 8) begin
      @(negedge clk);
      lat++;
    end
    check(req, $sformatf("miss @%0h", a), int'(c_miss), int'(exp_miss));
    check(req, $sformatf("err @%0h", a), int'(c_err), int'(exp_err));
    check(req, $sformatf("latency @%0h", a), lat, exp_lat);
    check(req, $sformatf("ready after accept @%0h", a), int'(rdy1), (exp_lat == 1) ? 1 : 0);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R2", "ready after reset", int'(m_req_ready), 1);
    check("R2", "rsp_valid after reset", int'(m_rsp_valid), 0);
    access(0, 32'h8, 5'd1, 0, 0, 1, "R2");
    access(0, 32'h100, 5'd1, 1, 0, 1, "R6");
    access(0, 32'h100, 5'd1, 0, 0, 1, "R5");
    access(0, 32'h8, 5'd1, 0, 0, 1, "R6");
  endtask

  task automatic t_index();
    do_reset();
    access(0, 32'h35, 5'd1, 1, 0, 1, "R1");
    access(0, 32'h3F, 5'd1, 0, 0, 1, "R1");
    access(0, 32'h40, 5'd1, 1, 0, 1, "R1");
    access(0, 32'h30, 5'd4, 0, 0, 1, "R1");
  endtask

  task automatic t_evict();
    do_reset();
    access(0, 32'h030, 5'd1, 1, 0, 1, "R3");
    access(0, 32'h130, 5'd1, 1, 0, 1, "R3");
    access(0, 32'h230, 5'd1, 1, 0, 1, "R3");
    access(0, 32'h330, 5'd1, 1, 0, 1, "R3");
    access(0, 32'h430, 5'd1, 1, 0, 1, "R3");
    access(0, 32'h130, 5'd1, 0, 0, 1, "R4");
    access(0, 32'h030, 5'd1, 1, 0, 1, "R3");
    access(0, 32'h230, 5'd1, 1, 0, 1, "R3");
  endtask

  task automatic t_promote();
    do_reset();
    access(0, 32'h030, 5'd1, 1, 0, 1, "R4");
    access(0, 32'h130, 5'd1, 1, 0, 1, "R4");
    access(0, 32'h230, 5'd1, 1, 0, 1, "R4");
    access(0, 32'h330, 5'd1, 1, 0, 1, "R4");
    access(0, 32'h030, 5'd1, 0, 0, 1, "R4");
    access(0, 32'h430, 5'd1, 1, 0, 1, "R4");
    access(0, 32'h030, 5'd1, 0, 0, 1, "R4");
    access(0, 32'h130, 5'd1, 1, 0, 1, "R4");
  endtask

  task automatic t_mru();
    do_reset();
    access(0, 32'h030, 5'd1, 1, 0, 1, "R5");
    access(0, 32'h130, 5'd1, 1, 0, 1, "R5");
    access(0, 32'h230, 5'd1, 1, 0, 1, "R5");
    access(0, 32'h330, 5'd1, 1, 0, 1, "R5");
    access(0, 32'h330, 5'd1, 0, 0, 1, "R5");
    access(0, 32'h430, 5'd1, 1, 0, 1, "R5");
    access(0, 32'h130, 5'd1, 0, 0, 1, "R5");
    access(0, 32'h030, 5'd1, 1, 0, 1, "R5");
  endtask

  task automatic t_straddle();
    do_reset();
    access(0, 32'h3E, 5'd4, 1, 0, 2, "R8");
    access(0, 32'h30, 5'd1, 0, 0, 1, "R8");
    access(0, 32'h40, 5'd1, 0, 0, 1, "R8");
    access(0, 32'h4E, 5'd4, 1, 0, 2, "R8");
    access(0, 32'h3C, 5'd8, 0, 0, 2, "R8");
    access(0, 32'h2E, 5'd4, 1, 0, 2, "R8");
    access(0, 32'h50, 5'd16, 0, 0, 1, "R7");
  endtask

  task automatic t_error();
    do_reset();
    access(0, 32'h3F, 5'd18, 0, 1, 1, "R9");
    access(0, 32'h30, 5'd1, 1, 0, 1, "R9");
    access(0, 32'h40, 5'd1, 1, 0, 1, "R9");
    access(0, 32'h50, 5'd1, 1, 0, 1, "R9");
  endtask

  task automatic t_backpressure();
    do_reset();
    sel = 0;
    @(negedge clk);
    m_rsp_ready = 0;
    m_req_valid = 1; m_req_addr = 32'h30; m_req_size = 1;
    @(posedge clk);
    @(negedge clk);
    check("R10", "rsp_valid pending", int'(m_rsp_valid), 1);
    check("R10", "ready while stalled", int'(m_req_ready), 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10", "valid held", int'(m_rsp_valid), 1);
      check("R10", "miss held", int'(m_rsp_miss), 1);
      check("R10", "ready held low", int'(m_req_ready), 0);
    end
    m_rsp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    m_req_valid = 0;
    check("R10", "second rsp valid", int'(m_rsp_valid), 1);
    check("R10", "second rsp hit", int'(m_rsp_miss), 0);
    @(negedge clk);
  endtask

  task automatic t_direct();
    do_reset();
    access(1, 32'h030, 5'd1, 1, 0, 1, "R11");
    access(1, 32'h030, 5'd1, 0, 0, 1, "R11");
    access(1, 32'h130, 5'd1, 1, 0, 1, "R11");
    access(1, 32'h030, 5'd1, 1, 0, 1, "R11");
    access(1, 32'h040, 5'd1, 1, 0, 1, "R11");
    access(1, 32'h030, 5'd1, 0, 0, 1, "R11");
    sel = 0;
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_index();
    t_evict();
    t_promote();
    t_mru();
    t_straddle();
    t_error();
    t_backpressure();
    t_direct();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule